// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a down-counting watchdog that software controls through a small register interface. Software puts a start value into the load register and picks the action to take on expiry. It then starts the timer with a key value written to the control register. While the timer runs, the counter drops by one every clock. Any write to the service register puts the load value back into the counter. If the counter sits at zero and no service write arrives in that cycle, the timer expires.

On expiry the block drives one of three outputs, chosen by the action field: a one-cycle system reset request, a nonmaskable interrupt, or a general-purpose interrupt. A fourth code drives nothing. Each interrupt output is a level. It stays high until software services or stops the timer. A reset-cause flag records that a reset came from this block. The flag sits in a domain that only power-on reset clears, so it survives the system reset it asked for, and software can read it afterwards. Two inputs reset the block: `por` clears everything, and `rst` clears everything except the cause flag.

Top module: `wdt_top`

## Requirements
- R1: After `por` or `rst`, the timer is stopped and all three outputs are low. The control, load and counter reads all return 0, except that after `rst` alone the cause flag keeps its value.
- R2: While the timer runs, the counter value, read at address 3, falls by exactly one per clock until it reaches 0, and then holds at 0.
- R3: When no service write arrives, the selected output rises on the clock edge N+1 edges after the start write, where N is the load value. A load value of 0 is legal.
- R4: A write of any data to address 2 reloads the counter from the load register (address 1) and drops both interrupt outputs at that edge.
- R5: Action field bits [1:0] of the control register select the expiry output: 0 gives `rst_req`, 1 gives `nmi`, 2 gives `irq`, 3 gives no output. Only the selected output ever rises.
- R6: `rst_req` is high for exactly one cycle. `nmi` and `irq` stay high until a service write or a stop.
- R7: Control-register bit 31 is the cause flag. It is set on the same edge as `rst_req`, it is kept through `rst`, and it is cleared by `por` or by a control write with bit 31 at 1.
- R8: A control write with bits [15:8] equal to 0xE1 starts a stopped timer and loads the counter from the load register. A write with bits [15:8] equal to 0xAD stops the timer: the counter holds its value and the outputs drop. Any other value in bits [15:8] leaves the run state as it is. Control-register bit 8 reads back the run state.
- R9: A write to the action field while the timer runs is ignored, and the old action stays in effect.
- R10: A write to the load register while the timer is stopped also sets the counter. While the timer runs, the new load value takes effect only at the next service write.
- R11: A service write in the cycle in which the counter reads 0 prevents the expiry.
- R12: Each expiry produces a single event. After a reset request, no further `rst_req` pulse occurs until software services or restarts the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears everything |
| rst | input | 1 | System reset, synchronous, active high; keeps the cause flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 load, 2 service, 3 counter (read only) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | CNT_W | Read data, combinational from `rd_addr` |
| rst_req | output | 1 | One-cycle system reset request |
| nmi | output | 1 | Nonmaskable interrupt level |
| irq | output | 1 | General-purpose interrupt level |

## Verification
The hardest cases to reach from the ports are those that fall on the exact cycle of expiry: a service write in the one cycle where the counter reads zero, and the single-cycle reset request followed by a system reset that must leave the cause flag intact. The bench drives at the falling edge and counts edges from the start write. This lets it place a service write on that exact cycle. It also pulses `rst` right after the reset request and then reads the flag back. Random trials vary the load value, the action code and the number and timing of service writes. Directed cases cover stop, action writes while running, and load writes while running.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ACT_RESET = 2'd0,
        ACT_NMI   = 2'd1,
        ACT_IRQ   = 2'd2,
        ACT_NONE  = 2'd3
    } act_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LOAD = 2'd1;
    localparam logic [1:0] ADDR_SVC  = 2'd2;
    localparam logic [1:0] ADDR_CUR  = 2'd3;

    localparam logic [7:0] KEY_RUN  = 8'hE1;
    localparam logic [7:0] KEY_STOP = 8'hAD;

    localparam int KEY_LSB  = 8;
    localparam int RUN_BIT  = 8;

    typedef struct packed {
        logic start;
        logic stop;
        logic svc;
        logic load_wr;
        logic act_wr;
        logic cause_clr;
        act_e act;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic wr_en, input logic [1:0] addr,
                                        input logic [7:0] key, input logic [1:0] act,
                                        input logic clr_bit);
        cmd_t c;
        c.start     = wr_en && addr == ADDR_CTRL && key == KEY_RUN;
        c.stop      = wr_en && addr == ADDR_CTRL && key == KEY_STOP;
        c.act_wr    = wr_en && addr == ADDR_CTRL;
        c.cause_clr = wr_en && addr == ADDR_CTRL && clr_bit;
        c.svc       = wr_en && addr == ADDR_SVC;
        c.load_wr   = wr_en && addr == ADDR_LOAD;
        c.act       = act_e'(act);
        return c;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    input  logic             run_q,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             cause_q,
    output cmd_t             cmd,
    output logic [CNT_W-1:0] load_q,
    output act_e             act_q,
    output logic [CNT_W-1:0] rd_data
);
    localparam int CAUSE_BIT = CNT_W - 1;

    always_comb begin
        cmd = decode_cmd(wr_en, wr_addr, wr_data[KEY_LSB +: 8], wr_data[1:0],
                         wr_data[CAUSE_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            act_q  <= ACT_RESET;
        end else begin
            if (cmd.load_wr)
                load_q <= wr_data;
            // action may change only while stopped
            if (cmd.act_wr && !run_q)
                act_q <= cmd.act;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[1:0]      = act_q;
                rd_data[RUN_BIT]  = run_q;
                rd_data[CAUSE_BIT] = cause_q;
            end
            ADDR_LOAD: rd_data = load_q;
            ADDR_SVC:  rd_data = '0;
            ADDR_CUR:  rd_data = cnt_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] load_q,
    output logic             run_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    logic             expd_q, expd_n, run_n;
    logic [CNT_W-1:0] cnt_n;

    always_comb begin
        run_n  = run_q;
        cnt_n  = cnt_q;
        expd_n = expd_q;
        // an expiry fires once; a service or stop in the same cycle wins
        expire = run_q && cnt_q == '0 && !expd_q && !cmd.svc && !cmd.stop;
        if (expire)
            expd_n = 1'b1;
        if (cmd.stop) begin
            run_n  = 1'b0;
            expd_n = 1'b0;
        end else if (cmd.start && !run_q) begin
            run_n  = 1'b1;
            cnt_n  = load_q;
            expd_n = 1'b0;
        end else if (cmd.svc) begin
            cnt_n  = load_q;
            expd_n = 1'b0;
        end else if (cmd.load_wr && !run_q) begin
            cnt_n  = wr_data;
        end else if (run_q && cnt_q != '0) begin
            cnt_n  = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            expd_q <= 1'b0;
        end else begin
            run_q  <= run_n;
            cnt_q  <= cnt_n;
            expd_q <= expd_n;
        end
    end
endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic expire,
    input  act_e act_q,
    input  cmd_t cmd,
    output logic rst_req,
    output logic nmi,
    output logic irq,
    output logic cause_q
);
    logic quiet;
    assign quiet = cmd.svc || cmd.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
            nmi     <= 1'b0;
            irq     <= 1'b0;
        end else begin
            rst_req <= expire && act_q == ACT_RESET;
            nmi     <= (nmi || (expire && act_q == ACT_NMI)) && !quiet;
            irq     <= (irq || (expire && act_q == ACT_IRQ)) && !quiet;
        end
    end

    // cause flag: power-on domain only, set has priority over clear
    always_ff @(posedge clk) begin
        if (por)
            cause_q <= 1'b0;
        else if (expire && act_q == ACT_RESET)
            cause_q <= 1'b1;
        else if (cmd.cause_clr)
            cause_q <= 1'b0;
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             por,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             rst_req,
    output logic             nmi,
    output logic             irq
);
    logic             sys_rst;
    cmd_t             cmd;
    logic [CNT_W-1:0] load_q, cnt_q;
    act_e             act_q;
    logic             run_q, expire, cause_q;

    assign sys_rst = rst || por;

    wdt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(sys_rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .run_q(run_q), .cnt_q(cnt_q),
        .cause_q(cause_q), .cmd(cmd), .load_q(load_q), .act_q(act_q),
        .rd_data(rd_data)
    );

    wdt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(sys_rst), .cmd(cmd), .wr_data(wr_data),
        .load_q(load_q), .run_q(run_q), .cnt_q(cnt_q), .expire(expire)
    );

    wdt_action act_i (
        .clk(clk), .rst(sys_rst), .por(por), .expire(expire), .act_q(act_q),
        .cmd(cmd), .rst_req(rst_req), .nmi(nmi), .irq(irq), .cause_q(cause_q)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             por,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             rst_req,
    input logic             nmi,
    input logic             irq,
    input logic             run_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             cause_q
);
    a_r6_rst_pulse: assert property (@(posedge clk) disable iff (rst || por)
        rst_req |=> !rst_req);

    a_r5_one_output: assert property (@(posedge clk) disable iff (rst || por)
        $onehot0({rst_req, nmi, irq}));

    a_r7_cause_with_req: assert property (@(posedge clk) disable iff (rst || por)
        rst_req |-> cause_q);

    a_r7_cause_kept: assert property (@(posedge clk) disable iff (por)
        (cause_q && !(wr_en && wr_addr == ADDR_CTRL && wr_data[CNT_W-1])) |=> cause_q);

    a_r4_service_clears: assert property (@(posedge clk) disable iff (rst || por)
        (wr_en && wr_addr == ADDR_SVC) |=> (!nmi && !irq));

    a_r2_decrement: assert property (@(posedge clk) disable iff (rst || por)
        (run_q && cnt_q != '0 && !wr_en) |=> cnt_q == $past(cnt_q) - 1'b1);

    a_r8_stopped_holds: assert property (@(posedge clk) disable iff (rst || por)
        (!run_q && !wr_en) |=> $stable(cnt_q));
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rst_req(rst_req), .nmi(nmi), .irq(irq),
    .run_q(run_q), .cnt_q(cnt_q), .cause_q(cause_q)
);

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         por = 1'b1, rst = 1'b0, wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0, rd_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         rst_req, nmi, irq;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wdt_top #(.CNT_W(W)) dut_i (
        .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rst_req(rst_req), .nmi(nmi), .irq(irq)
    );

    function automatic logic [W-1:0] mk_ctrl(input logic [7:0] key, input logic [1:0] act,
                                             input logic clr);
        logic [W-1:0] v = '0;
        v[15:8] = key; v[1:0] = act; v[W-1] = clr;
        return v;
    endfunction

    function automatic logic [2:0] exp_outs(input logic [1:0] act);
        case (act)
            2'd0: return 3'b100;
            2'd1: return 3'b010;
            2'd2: return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [W-1:0] exp_ctrl(input logic cause, input logic run,
                                              input logic [1:0] act);
        logic [W-1:0] v = '0;
        v[W-1] = cause; v[8] = run; v[1:0] = act;
        return v;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    function automatic logic [W-1:0] outs();
        return {29'd0, rst_req, nmi, irq};
    endfunction

    task automatic do_rst(input bit power);
        if (power) por = 1'b1; else rst = 1'b1;
        tick();
        por = 1'b0; rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        int unsigned seed;
        seed = $urandom(32'h5eed);
        tick(2);
        por = 1'b0;

        // R1: state after power-on reset
        rd(0, v); check("R1 ctrl", v, '0);
        rd(1, v); check("R1 load", v, '0);
        rd(3, v); check("R1 counter", v, '0);
        check("R1 outputs", outs(), '0);

        // R3/R5/R6/R7/R12: reset action with load 0
        wr(1, 32'd0);
        wr(0, mk_ctrl(8'hE1, 2'd0, 1'b0));
        check("R3 no output yet", outs(), '0);
        tick(); check("R3 R5 rst_req at N+1", outs(), 32'd4);
        rd(0, v); check("R7 cause set", v, exp_ctrl(1, 1, 0));
        tick(); check("R6 pulse one cycle", outs(), '0);
        tick(6); check("R12 no second pulse", outs(), '0);
        do_rst(0);
        rd(0, v); check("R7 cause kept over rst", v, exp_ctrl(1, 0, 0));
        check("R1 outputs after rst", outs(), '0);
        do_rst(1);
        rd(0, v); check("R7 cause cleared by por", v, '0);

        // R11: service exactly when counter reads zero
        wr(1, 32'd5);
        wr(0, mk_ctrl(8'hE1, 2'd1, 1'b0));
        tick(5);
        rd(3, v); check("R2 counter at zero", v, '0);
        wr(2, 32'hDEAD);
        check("R11 expiry prevented", outs(), '0);
        rd(3, v); check("R11 reload", v, 32'd5);

        // R9 / R8: action write with neutral key while running
        wr(0, mk_ctrl(8'h00, 2'd2, 1'b0));
        rd(0, v); check("R9 action unchanged", v, exp_ctrl(0, 1, 1));
        rd(3, v); check("R8 neutral key keeps running", v, 32'd4);
        tick(4);
        check("R3 not yet", outs(), '0);
        tick(); check("R9 old action used", outs(), 32'd2);
        tick(3); check("R6 nmi held", outs(), 32'd2);

        // R10: load write while running waits for service
        wr(1, 32'd9);
        rd(3, v); check("R10 counter not loaded while running", v, '0);
        wr(2, 32'd0);
        check("R4 service drops nmi", outs(), '0);
        rd(3, v); check("R10 new value at service", v, 32'd9);

        // R8: stop holds counter
        tick(3);
        wr(0, mk_ctrl(8'hAD, 2'd0, 1'b0));
        rd(3, v); check("R8 stop counter", v, 32'd6);
        tick(5);
        rd(3, v); check("R8 counter held", v, 32'd6);
        rd(0, v); check("R8 run bit low", v, exp_ctrl(0, 0, 1));
        wr(1, 32'd3);
        rd(3, v); check("R10 load while stopped", v, 32'd3);
        wr(0, mk_ctrl(8'hAD, 2'd2, 1'b0));
        rd(0, v); check("R9 action takes while stopped", v, exp_ctrl(0, 0, 2));

        // R7: write-one clears cause
        do_rst(0);
        wr(1, 32'd1);
        wr(0, mk_ctrl(8'hE1, 2'd0, 1'b0));
        tick(2); check("R5 reset chosen", outs(), 32'd4);
        wr(0, mk_ctrl(8'h00, 2'd0, 1'b1));
        rd(0, v); check("R7 write one clears", v[W-1], '0);

        // random trials
        for (int t = 0; t < 30; t++) begin
            int n, a, ns;
            do_rst(1);
            n  = $urandom_range(0, 40);
            a  = $urandom_range(0, 3);
            ns = $urandom_range(0, 2);
            wr(1, W'(n));
            wr(0, mk_ctrl(8'hE1, 2'(a), 1'b0));
            rd(3, v); check("R8 start loads", v, W'(n));
            for (int s = 0; s < ns; s++) begin
                int k;
                k = $urandom_range(0, n);
                tick(k);
                rd(3, v); check("R2 countdown", v, W'(n - k));
                wr(2, W'($urandom));
                rd(3, v); check("R4 reload", v, W'(n));
            end
            tick(n);
            check("R3 quiet before expiry", outs(), '0);
            tick();
            check("R5 expiry output", outs(), {29'd0, exp_outs(2'(a))});
            tick();
            if (a == 0) begin
                check("R6 pulse ends", outs(), '0);
                do_rst(0);
                rd(0, v); check("R7 cause survives", v[W-1], 1'b1);
            end else begin
                check("R6 level held", outs(), {29'd0, exp_outs(2'(a))});
                wr(2, '0);
                check("R4 service clears", outs(), '0);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule